// File: doc/BRIEF.md
# Next-PC Instruction Fetch Unit

This block owns the program counter of a single-cycle processor and decides, on every rising clock edge, where the next instruction comes from. Each cycle it offers the current instruction word address to an instruction memory. The decoder and the ALU return three pieces of information about the fetched instruction: a branch indicator, the ALU equality flag, and a jump request. They also return the 16-bit immediate and 26-bit target fields of that instruction.

The next address comes from one of three sources. The first is the sequential address, PC plus four. The second is a PC-relative target, used when a branch instruction finds its two operands equal. The third is an absolute target inside the current 256 MiB region, built from the four upper PC bits, the 26-bit target and two zero bits. A jump request overrides the other two sources. The branch indicator only says "this is a branch". The unit ANDs it with the equality flag to decide whether the branch is taken.

Top module: `nxtpc_fetch`

## Requirements
- R1: While `rst` is 1 at a rising edge, `pc_q` becomes 0 after that edge, whatever the other inputs are.
- R2: With `jump_en`=0 and not both `br_is_branch`=1 and `alu_eq`=1, the next PC is the current PC plus 4.
- R3: With `jump_en`=0, `br_is_branch`=1 and `alu_eq`=1, the next PC is PC + 4 + 4·imm. Here imm is `imm_field` read as a two's-complement 16-bit number.
- R4: A branch is not taken when only one of `br_is_branch` and `alu_eq` is 1. A lone `alu_eq`=1 on a non-branch cycle has no effect on the next PC.
- R5: With `jump_en`=1, the next PC is built from three parts. Bits [31:28] are the current PC bits [31:28]. Bits [27:2] equal `tgt_field`. Bits [1:0] are 0.
- R6: `jump_en`=1 takes priority over a taken branch.
- R7: `imem_word_addr` always equals `pc_q[31:2]`.
- R8: All PC arithmetic is modulo 2^32. PC 0xFFFFFFFC steps to 0, and a negative offset from 0 wraps to the top of the space.
- R9: The two low bits of `pc_q` stay 0 out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| br_is_branch | input | 1 | Current instruction is an equal-branch |
| alu_eq | input | 1 | ALU result is zero (operands equal) |
| jump_en | input | 1 | Current instruction is an absolute jump |
| imm_field | input | 16 | Immediate field of the current instruction |
| tgt_field | input | 26 | Jump target field of the current instruction |
| pc_q | output | 32 | Current program counter |
| imem_word_addr | output | 30 | Instruction memory word address |

## Verification
The bench sends the most negative and most positive immediates. A design that zero-extended the immediate, or forgot the shift by two, would land on a wrong address. It branches backwards from address 0 and steps forward from 0xFFFFFFFC to catch adders that saturate or carry out incorrectly. It jumps from the top region to expose a design that takes the region bits from zero or from PC+4. It sweeps all eight combinations of the three control bits so that an OR in place of the AND, or a branch beating the jump, changes the next PC.

// File: rtl/nxtpc_pkg.sv
package nxtpc_pkg;
  localparam int PC_W   = 32;
  localparam int IMM_W  = 16;
  localparam int TGT_W  = 26;
  localparam int ALIGN  = 2;
  localparam int RGN_W  = PC_W - TGT_W - ALIGN;
  localparam int WORD_W = PC_W - ALIGN;

  typedef logic [PC_W-1:0]  pc_t;
  typedef logic [IMM_W-1:0] imm_t;
  typedef logic [TGT_W-1:0] tgt_t;

  typedef enum logic [1:0] {
    SRC_SEQ    = 2'd0,
    SRC_BRANCH = 2'd1,
    SRC_JUMP   = 2'd2
  } nxt_src_e;

  // Sign-extended immediate scaled to a byte offset.
  function automatic pc_t branch_offset(input imm_t imm);
    return {{(PC_W-IMM_W-ALIGN){imm[IMM_W-1]}}, imm, {ALIGN{1'b0}}};
  endfunction

  function automatic pc_t seq_step(input pc_t pc);
    return pc + pc_t'(1 << ALIGN);
  endfunction
endpackage

// File: rtl/nxtpc_rel_target.sv
module nxtpc_rel_target
  import nxtpc_pkg::*;
(
  input  pc_t  pc_cur,
  input  imm_t imm,
  output pc_t  pc_seq,
  output pc_t  pc_branch
);
  always_comb begin
    pc_seq    = seq_step(pc_cur);
    pc_branch = pc_seq + branch_offset(imm);
  end
endmodule

// File: rtl/nxtpc_abs_target.sv
module nxtpc_abs_target
  import nxtpc_pkg::*;
(
  input  pc_t  pc_cur,
  input  tgt_t tgt,
  output pc_t  pc_jump
);
  generate
    if (RGN_W > 0) begin : g_region
      assign pc_jump = {pc_cur[PC_W-1 -: RGN_W], tgt, {ALIGN{1'b0}}};
    end else begin : g_flat
      assign pc_jump = pc_t'({tgt, {ALIGN{1'b0}}});
    end
  endgenerate
endmodule

// File: rtl/nxtpc_select.sv
module nxtpc_select
  import nxtpc_pkg::*;
(
  input  logic     is_branch,
  input  logic     eq_flag,
  input  logic     jump,
  input  pc_t      pc_seq,
  input  pc_t      pc_branch,
  input  pc_t      pc_jump,
  output nxt_src_e src,
  output pc_t      pc_next
);
  logic taken;
  assign taken = is_branch & eq_flag;

  always_comb begin
    if (jump)       src = SRC_JUMP;
    else if (taken) src = SRC_BRANCH;
    else            src = SRC_SEQ;
  end

  always_comb begin
    unique case (src)
      SRC_JUMP:   pc_next = pc_jump;
      SRC_BRANCH: pc_next = pc_branch;
      default:    pc_next = pc_seq;
    endcase
  end
endmodule

// File: rtl/nxtpc_fetch.sv
module nxtpc_fetch
  import nxtpc_pkg::*;
#(
  parameter pc_t RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              br_is_branch,
  input  logic              alu_eq,
  input  logic              jump_en,
  input  logic [IMM_W-1:0]  imm_field,
  input  logic [TGT_W-1:0]  tgt_field,
  output logic [PC_W-1:0]   pc_q,
  output logic [WORD_W-1:0] imem_word_addr
);
  pc_t      pc_r;
  pc_t      seq_pc, branch_pc, jump_pc, next_pc;
  nxt_src_e src_sel;

  nxtpc_rel_target u_rel (
    .pc_cur(pc_r), .imm(imm_field), .pc_seq(seq_pc), .pc_branch(branch_pc)
  );

  nxtpc_abs_target u_abs (
    .pc_cur(pc_r), .tgt(tgt_field), .pc_jump(jump_pc)
  );

  nxtpc_select u_sel (
    .is_branch(br_is_branch), .eq_flag(alu_eq), .jump(jump_en),
    .pc_seq(seq_pc), .pc_branch(branch_pc), .pc_jump(jump_pc),
    .src(src_sel), .pc_next(next_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) pc_r <= RESET_PC;
    else     pc_r <= next_pc;
  end

  assign pc_q           = pc_r;
  assign imem_word_addr = pc_r[PC_W-1:ALIGN];

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (!jump_en && !(br_is_branch && alu_eq)) |=> pc_q == $past(pc_q) + 32'd4); // R2
  AST_BRANCH_STEP: assert property (@(posedge clk) disable iff (rst)
    (!jump_en && br_is_branch && alu_eq)
      |=> pc_q == $past(pc_q) + 32'd4 + branch_offset($past(imm_field))); // R3
  AST_JUMP_REGION: assert property (@(posedge clk) disable iff (rst)
    jump_en |=> (pc_q[PC_W-1 -: RGN_W] == $past(pc_q[PC_W-1 -: RGN_W]))
                && (pc_q[PC_W-RGN_W-1:ALIGN] == $past(tgt_field))); // R5
  AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> pc_q[ALIGN-1:0] == '0); // R9
endmodule

// File: tb/nxtpc_fetch_tb.sv
module nxtpc_fetch_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        br_is_branch, alu_eq, jump_en;
  logic [15:0] imm_field;
  logic [25:0] tgt_field;
  logic [31:0] pc_q;
  logic [29:0] imem_word_addr;

  int checks = 0;
  int errors = 0;
  logic [31:0] model;

  always #2 clk = ~clk;

  nxtpc_fetch u_dut (
    .clk(clk), .rst(rst), .br_is_branch(br_is_branch), .alu_eq(alu_eq),
    .jump_en(jump_en), .imm_field(imm_field), .tgt_field(tgt_field),
    .pc_q(pc_q), .imem_word_addr(imem_word_addr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // Reference next PC written as integer arithmetic.
  function automatic logic [31:0] ref_next(input logic [31:0] pc, input logic j,
      input logic b, input logic z, input logic [15:0] imm, input logic [25:0] tgt);
    longint off;
    if (j) return (pc & 32'hF000_0000) | (32'(tgt) * 4);
    off = longint'($signed(imm)) * 4;
    if (b && z) return 32'(longint'(pc) + 4 + off);
    return 32'(longint'(pc) + 4);
  endfunction

  // Inputs applied at negedge, result sampled at the following negedge.
  task automatic step(input string req, input logic j, input logic b, input logic z,
                      input logic [15:0] imm, input logic [25:0] tgt);
    jump_en = j; br_is_branch = b; alu_eq = z; imm_field = imm; tgt_field = tgt;
    model = ref_next(model, j, b, z, imm, tgt);
    @(posedge clk);
    @(negedge clk);
    check(req, pc_q, model);
    check("R7", {imem_word_addr, 2'b00}, pc_q);
    check("R9", {30'd0, pc_q[1:0]}, 32'd0);
  endtask

  task automatic do_reset();
    rst = 1'b1; jump_en = 1'b1; br_is_branch = 1'b1; alu_eq = 1'b1;
    imm_field = 16'h7FFF; tgt_field = 26'h3FF_FFFF;
    @(posedge clk); @(negedge clk);
    check("R1", pc_q, 32'd0);
    @(posedge clk); @(negedge clk);
    check("R1", pc_q, 32'd0);
    rst = 1'b0;
    model = 32'd0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    rst = 1'b1; jump_en = 0; br_is_branch = 0; alu_eq = 0; imm_field = 0; tgt_field = 0;
    model = 0;
    @(negedge clk);
    do_reset();

    step("R2", 0, 0, 0, 16'h1234, 26'h0);
    step("R4", 0, 0, 1, 16'h0100, 26'h0);           // zero flag alone
    step("R4", 0, 1, 0, 16'h0100, 26'h0);           // branch, operands unequal
    step("R3", 0, 1, 1, 16'h0003, 26'h0);
    step("R3", 0, 1, 1, 16'h7FFF, 26'h0);           // max forward
    step("R3", 0, 1, 1, 16'h8000, 26'h0);           // max backward
    step("R5", 1, 0, 0, 16'h0000, 26'h155_5555);
    step("R6", 1, 1, 1, 16'h0040, 26'h000_0010);    // jump beats branch

    do_reset();
    step("R8", 0, 1, 1, 16'hFFFE, 26'h0);           // 0 -> 0xFFFFFFFC
    check("R8", pc_q, 32'hFFFF_FFFC);
    step("R5", 1, 0, 0, 16'h0, 26'h000_0001);       // region F kept
    check("R5", pc_q, 32'hF000_0004);
    step("R5", 1, 0, 0, 16'h0, 26'h3FF_FFFF);
    check("R5", pc_q, 32'hFFFF_FFFC);
    step("R8", 0, 0, 0, 16'h0, 26'h0);              // wrap to 0
    check("R8", pc_q, 32'd0);

    // Sweep all control combinations with pseudo-random fields.
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step((i % 8) >= 4 ? "R6" : ((i % 8) == 3 ? "R3" : "R4"),
           (i % 8) >= 4, i[1], i[0], lfsr, {lfsr[9:0], ~lfsr});
    end

    // Reset in mid-flow.
    step("R2", 0, 0, 0, 16'h0, 26'h0);
    do_reset();
    step("R2", 0, 0, 0, 16'h0, 26'h0);
    check("R2", pc_q, 32'd4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule